// File: doc/BRIEF.md
# Flag-Steered Two-Operand Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit with a parameterised data width (16 bits by default). It takes two operands and a 6-bit control word and produces one result word. There is no opcode decoder. Each control bit is an independent switch that shapes the data path.

Each operand passes through its own conditioning stage. That stage can force the operand to zero and can then take its bitwise complement. A shared core then either adds the two conditioned operands or ANDs them bit by bit. A final stage can complement the core output.

Different control words therefore give AND, OR, NAND, ADD, both subtraction orders, increment and decrement, and constants. Two status outputs come from the final result: one flags an all-zero word and one repeats its sign bit. The block holds no state and has no clock.

Top module: `flag_alu`

## Requirements
- R1: Control bit 0 forces operand A to zero, and control bit 1 complements operand A. Forcing to zero is applied before complementing, so with both bits set operand A becomes all ones.
- R2: Control bit 2 forces operand B to zero, and control bit 3 complements operand B. Forcing to zero is applied first, so with both bits set operand B becomes all ones.
- R3: Control bit 4 selects the core function. When it is 1 the core adds the two conditioned operands; when it is 0 the core takes their bitwise AND.
- R4: Control bit 5 complements the core output as the very last step.
- R5: Control word 6'h00 yields A AND B, and 6'h20 yields A NAND B.
- R6: Control word 6'h3F yields the constant 1, for any operands.
- R7: Control word 6'h32 yields A minus B, and control word 6'h38 yields B minus A.
- R8: Control word 6'h2A yields A OR B.
- R9: Control word 6'h1C yields A minus 1, and control word 6'h3E yields A plus 1.
- R10: Addition wraps modulo 2^W, and the carry out of the top bit is dropped. Control word 6'h10 yields A plus B truncated to W bits.
- R11: The zero status output is 1 exactly when the result is all zeros. Control word 6'h05 yields 0 with zero status 1.
- R12: The negative status output equals the most significant bit of the result. Control word 6'h17 yields all ones (−1) with negative status 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | W | Operand A |
| opb_i | input | W | Operand B |
| ctrl_i | input | 6 | Control flags; bit 0 zero A, bit 1 invert A, bit 2 zero B, bit 3 invert B, bit 4 add, bit 5 invert result |
| res_o | output | W | Result word |
| zero_o | output | 1 | High when the result is all zeros |
| neg_o | output | 1 | Most significant bit of the result |

## Verification
Wrap-around of the adder and the zero status can occur on the same evaluation. Operand pairs whose sum is exactly 2^W (0x8000 + 0x8000, 0xFFFF + 0x0001) provoke this. In that case the result must read zero, the zero status must be high, the negative status must be low, and there must be no trace of the lost carry.

A second coincidence can occur inside one operand stage, when force-to-zero and complement are active at once. Each such combination is judged against an operand model in which zeroing happens first. A sweep over all 64 control words with several operand pairs compares every output against that model.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    // Control word layout, most significant field first, so that
    // bit 0 is zero_a and bit 5 is inv_res.
    typedef struct packed {
        logic inv_res;
        logic use_add;
        logic inv_b;
        logic zero_b;
        logic inv_a;
        logic zero_a;
    } alu_ctrl_t;

    localparam int CTRL_W  = $bits(alu_ctrl_t);
    localparam int N_OPNDS = 2;

endpackage

// File: rtl/fa_operand_cond.sv
module fa_operand_cond #(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    input  logic         zero_i,
    input  logic         inv_i,
    output logic [W-1:0] val_o
);

    logic [W-1:0] gated;

    // Zeroing happens first; complementing is applied to what remains.
    always_comb begin
        gated = zero_i ? '0 : val_i;
        val_o = inv_i ? ~gated : gated;
    end

endmodule

// File: rtl/fa_core.sv
module fa_core #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         use_add_i,
    output logic [W-1:0] y_o
);

    logic [W:0]   sum_full;
    logic [W-1:0] and_word;

    always_comb begin
        sum_full = {1'b0, a_i} + {1'b0, b_i};
        and_word = a_i & b_i;
        // The carry in bit W is dropped here.
        y_o      = use_add_i ? sum_full[W-1:0] : and_word;
    end

endmodule

// File: rtl/fa_out_stage.sv
module fa_out_stage #(
    parameter int W = 16
) (
    input  logic [W-1:0] core_i,
    input  logic         inv_i,
    output logic [W-1:0] res_o,
    output logic         zero_o,
    output logic         neg_o
);

    logic [W-1:0] final_word;

    always_comb begin
        final_word = inv_i ? ~core_i : core_i;
        res_o      = final_word;
        zero_o     = ~|final_word;
        neg_o      = final_word[W-1];
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]      opa_i,
    input  logic [W-1:0]      opb_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [W-1:0]      res_o,
    output logic              zero_o,
    output logic              neg_o
);

    alu_ctrl_t    ctl;
    logic [W-1:0] opnd_raw  [N_OPNDS];
    logic [W-1:0] opnd_cond [N_OPNDS];
    logic         opnd_zero [N_OPNDS];
    logic         opnd_inv  [N_OPNDS];
    logic [W-1:0] core_word;

    always_comb begin
        ctl          = alu_ctrl_t'(ctrl_i);
        opnd_raw[0]  = opa_i;
        opnd_raw[1]  = opb_i;
        opnd_zero[0] = ctl.zero_a;
        opnd_zero[1] = ctl.zero_b;
        opnd_inv[0]  = ctl.inv_a;
        opnd_inv[1]  = ctl.inv_b;
    end

    for (genvar g = 0; g < N_OPNDS; g++) begin : g_opnd
        fa_operand_cond #(.W(W)) u_cond (
            .val_i  (opnd_raw[g]),
            .zero_i (opnd_zero[g]),
            .inv_i  (opnd_inv[g]),
            .val_o  (opnd_cond[g])
        );
    end

    fa_core #(.W(W)) u_core (
        .a_i       (opnd_cond[0]),
        .b_i       (opnd_cond[1]),
        .use_add_i (ctl.use_add),
        .y_o       (core_word)
    );

    fa_out_stage #(.W(W)) u_out (
        .core_i (core_word),
        .inv_i  (ctl.inv_res),
        .res_o  (res_o),
        .zero_o (zero_o),
        .neg_o  (neg_o)
    );

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
    parameter int W = 16
) (
    input logic [W-1:0] opa_i,
    input logic [W-1:0] opb_i,
    input logic [5:0]   ctrl_i,
    input logic [W-1:0] res_o,
    input logic         zero_o,
    input logic         neg_o
);

    logic [W-1:0] one_w;
    logic [W-1:0] a_minus_b;
    logic [W-1:0] a_plus_b;
    logic [W-1:0] a_minus_1;

    always_comb begin
        one_w     = {{(W-1){1'b0}}, 1'b1};
        a_minus_b = opa_i - opb_i;
        a_plus_b  = opa_i + opb_i;
        a_minus_1 = opa_i - one_w;
    end

    always_comb begin
        if (ctrl_i == 6'h3F) begin
            assert_all_flags_one_R6: assert (res_o == one_w && !zero_o && !neg_o)
                else $error("R6 all flags set did not give 1");
        end
        if (ctrl_i == 6'h00) begin
            assert_and_path_R5: assert (res_o == (opa_i & opb_i))
                else $error("R5 AND path mismatch");
        end
        if (ctrl_i == 6'h32) begin
            assert_sub_ab_R7: assert (res_o == a_minus_b)
                else $error("R7 A-B mismatch");
        end
        if (ctrl_i == 6'h10) begin
            assert_wrap_add_R10: assert (res_o == a_plus_b)
                else $error("R10 wrapped sum mismatch");
        end
        if (ctrl_i == 6'h1C) begin
            assert_decrement_R9: assert (res_o == a_minus_1)
                else $error("R9 decrement mismatch");
        end
        if (ctrl_i == 6'h05) begin
            assert_const_zero_R11: assert (zero_o && res_o == '0)
                else $error("R11 constant zero mismatch");
        end
    end

endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_flag_alu_chk (
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .ctrl_i (ctrl_i),
    .res_o  (res_o),
    .zero_o (zero_o),
    .neg_o  (neg_o)
);

// File: tb/test_flag_alu.sv
module test_flag_alu;

    localparam int W          = 16;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;

    typedef struct {
        string        tag;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [5:0]   c;
        logic [W-1:0] exp_res;
        logic         exp_zero;
        logic         exp_neg;
    } sb_item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [5:0]   ctrl = '0;
    logic [W-1:0] res;
    logic         zero_s;
    logic         neg_s;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_alu #(.W(W)) i_flag_alu (
        .opa_i  (opa),
        .opb_i  (opb),
        .ctrl_i (ctrl),
        .res_o  (res),
        .zero_o (zero_s),
        .neg_o  (neg_s)
    );

    // Reference written from the requirements: operand zero then invert
    // (R1, R2), add or AND (R3), final complement (R4).
    function automatic logic [W-1:0] ref_model(logic [W-1:0] a, logic [W-1:0] b, logic [5:0] c);
        logic [W-1:0] ca, cb, r;
        ca = c[0] ? '0 : a;
        if (c[1]) ca = ~ca;
        cb = c[2] ? '0 : b;
        if (c[3]) cb = ~cb;
        r = c[4] ? W'(ca + cb) : (ca & cb);
        if (c[5]) r = ~r;
        return r;
    endfunction

    task automatic drive(string tag, logic [W-1:0] a, logic [W-1:0] b, logic [5:0] c, logic [W-1:0] exp_r);
        sb_item_t it;
        @(negedge clk);
        opa = a;
        opb = b;
        ctrl = c;
        it.tag      = tag;
        it.a        = a;
        it.b        = b;
        it.c        = c;
        it.exp_res  = exp_r;
        it.exp_zero = (exp_r == '0);   // R11
        it.exp_neg  = exp_r[W-1];      // R12
        sb_q.push_back(it);
    endtask

    // Monitor: inputs change on the falling edge, outputs compared on the rising edge.
    always @(posedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_tests++;
            if (res !== it.exp_res || zero_s !== it.exp_zero || neg_s !== it.exp_neg) begin
                n_fail++;
                $display("FAIL %s a=%h b=%h c=%h: res=%h zero=%b neg=%b expected res=%h zero=%b neg=%b",
                         it.tag, it.a, it.b, it.c, res, zero_s, neg_s,
                         it.exp_res, it.exp_zero, it.exp_neg);
            end
        end
    end

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] pa [4];
        pa[0] = 16'h1234; pa[1] = 16'hFFFF; pa[2] = 16'h8000; pa[3] = 16'h00A5;

        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle state: zero operands, control 0 gives 0 with zero status.
        drive("R11 idle", '0, '0, 6'h00, '0);

        drive("R5 and",        16'hF0F0, 16'h3C3C, 6'h00, 16'h3030);
        drive("R5 nand",       16'hF0F0, 16'h3C3C, 6'h20, 16'hCFCF);
        drive("R6 const one",  16'h5A5A, 16'h1234, 6'h3F, 16'h0001);
        drive("R7 a minus b",  16'h0010, 16'h0003, 6'h32, 16'h000D);
        drive("R7 b minus a",  16'h0010, 16'h0003, 6'h38, 16'hFFF3);
        drive("R8 or",         16'hF000, 16'h000F, 6'h2A, 16'hF00F);
        drive("R9 decrement",  16'h0100, 16'h7777, 6'h1C, 16'h00FF);
        drive("R9 increment",  16'h00FF, 16'h7777, 6'h3E, 16'h0100);
        drive("R10 add",       16'h1234, 16'h0101, 6'h10, 16'h1335);
        drive("R10 wrap",      16'hFFFF, 16'h0002, 6'h10, 16'h0001);
        drive("R10 R11 wrap to zero", 16'h8000, 16'h8000, 6'h10, 16'h0000);
        drive("R11 const zero", 16'hABCD, 16'h1234, 6'h05, 16'h0000);
        drive("R12 minus one", 16'h1111, 16'h2222, 6'h17, 16'hFFFF);
        drive("R12 sign bit",  16'h8001, 16'hFFFF, 6'h00, 16'h8001);
        drive("R1 zero then invert a",  16'h1234, 16'h5A5A, 6'h03, 16'h5A5A);
        drive("R1 invert a",            16'h00FF, 16'h0F0F, 6'h02, 16'h0F00);
        drive("R2 zero then invert b",  16'h5A5A, 16'h1234, 6'h0C, 16'h5A5A);
        drive("R2 zero b",              16'h5A5A, 16'h1234, 6'h04, 16'h0000);
        drive("R3 add select",          16'h0003, 16'h0005, 6'h10, 16'h0008);
        drive("R3 and select",          16'h0003, 16'h0005, 6'h00, 16'h0001);
        drive("R4 invert result",       16'h0003, 16'h0005, 6'h30, 16'hFFF7);

        // Sweep every control word with several operand pairs (R1 to R4).
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < 64; c++) begin
                drive("R1 R2 R3 R4 sweep", pa[k], pa[(k+1)%4], 6'(c),
                      ref_model(pa[k], pa[(k+1)%4], 6'(c)));
            end
        end

        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule